// File: doc/BRIEF.md
# Privileged Coprocessor Register Access Controller

This block checks each 32-bit coprocessor register transfer request and decides whether the access goes ahead, is undefined, or is redirected as a trap to the hypervisor level. The decision uses the current exception level, whether the hypervisor level is enabled, whether that level runs 64-bit or 32-bit code, two hypervisor trap-enable bits (one for each register width), the non-secure state bit and a presence configuration input. When the access is allowed, the block reads or writes a 32-bit register. That register shares its storage with the upper half of a 64-bit control register, which has its own direct read and write port.

A request is presented for one cycle with `req_valid`. Exactly one cycle later, `rsp_valid` pulses with an outcome code, a no-match flag, read data and a trap syndrome. The surrounding pipeline acts on the outcome. Exception entry and the meaning of the register bits are handled elsewhere.

Top module: `cpreg_access_ctl`

## Requirements
- R1: A request selects the register only when coproc=4'b1111, opc1=3'b100, CRn=4'b0001, CRm=4'b0000 and opc2=3'b011. Any other encoding gives `rsp_nomatch`=1, `rsp_code`=2'b00, `rsp_rdata`=0 and `rsp_syndrome`=0, and leaves the storage unchanged.
- R2: When `present`=0, every matching access gives outcome 2'b01 (undefined). This check has priority over all other conditions.
- R3: With `cur_el`=2'b00 (least privileged level), a matching access gives outcome 2'b01.
- R4: With `cur_el`=2'b01, if `hyp_en`=1, `hyp_is64`=1 and `trap64_en`=1, the outcome is 2'b10 (trap to the 64-bit hypervisor) with `rsp_syndrome`=6'h03. In this case `trap32_en` is ignored.
- R5: With `cur_el`=2'b01, if `hyp_en`=1, `hyp_is64`=0 and `trap32_en`=1, the outcome is 2'b11 (32-bit hypervisor trap) with `rsp_syndrome`=6'h03. In this case `trap64_en` is ignored.
- R6: With `cur_el`=2'b01, when neither trap condition holds, the outcome is 2'b01.
- R7: With `cur_el`=2'b10 (hypervisor level), the outcome is 2'b00. A read returns the stored value and a write replaces it.
- R8: With `cur_el`=2'b11 (most privileged level), the outcome is 2'b01 when `nonsecure`=0. When `nonsecure`=1 the outcome is 2'b00 and the access behaves as in R7.
- R9: `wide_rdata[63:32]` always equals the 32-bit register. A write on the 64-bit port is seen by later 32-bit reads, and a 32-bit write is seen in `wide_rdata[63:32]` with bits [31:0] unchanged.
- R10: Only a write with outcome 2'b00 changes the storage. `rsp_rdata` is zero except for a read with outcome 2'b00. `rsp_syndrome` is zero except for outcomes 2'b10 and 2'b11.
- R11: Every request gives `rsp_valid` high for exactly the one cycle after the request cycle. Reset clears `rsp_valid` and the whole 64-bit storage.
- R12: When a 64-bit write and an allowed 32-bit write land on the same edge, bits [63:32] take the 32-bit write data and bits [31:0] take the 64-bit write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Transfer request strobe |
| req_write | input | 1 | 1 = write transfer, 0 = read transfer |
| req_coproc | input | 4 | Coprocessor number field |
| req_opc1 | input | 3 | First opcode field |
| req_crn | input | 4 | Primary register field |
| req_crm | input | 4 | Secondary register field |
| req_opc2 | input | 3 | Second opcode field |
| req_wdata | input | 32 | Write data |
| cur_el | input | 2 | Current exception level, 0 to 3 |
| hyp_en | input | 1 | Hypervisor level enabled |
| hyp_is64 | input | 1 | Hypervisor level runs 64-bit code |
| trap64_en | input | 1 | Trap enable bit used by a 64-bit hypervisor |
| trap32_en | input | 1 | Trap enable bit used by a 32-bit hypervisor |
| nonsecure | input | 1 | Non-secure state bit |
| present | input | 1 | Register is implemented |
| wide_we | input | 1 | 64-bit view write enable |
| wide_wdata | input | 64 | 64-bit view write data |
| wide_rdata | output | 64 | 64-bit view of the storage |
| rsp_valid | output | 1 | Response strobe |
| rsp_nomatch | output | 1 | Request did not select this register |
| rsp_code | output | 2 | Outcome: 00 OK, 01 undefined, 10 64-bit trap, 11 32-bit trap |
| rsp_rdata | output | 32 | Read data |
| rsp_syndrome | output | 6 | Trap syndrome code |

## Verification
Every response field is registered. The bench drives a request at a falling edge and samples `rsp_*` at the next falling edge, which is after the single capturing rising edge. Storage updates land on that same edge, so `wide_rdata` is compared with the bench's own model at that same sample point. A 64-bit write is visible through `wide_rdata` half a cycle after the edge that captures it. The single-cycle width of `rsp_valid` is checked one further cycle later, once `req_valid` has been dropped.

// File: rtl/cpreg_pkg.sv
package cpreg_pkg;
  localparam int DATA_W = 32;
  localparam int SYN_W  = 6;

  typedef enum logic [1:0] {
    OC_OK     = 2'b00,
    OC_UNDEF  = 2'b01,
    OC_TRAP64 = 2'b10,
    OC_TRAP32 = 2'b11
  } outcome_e;

  localparam logic [3:0] SEL_COPROC = 4'b1111;
  localparam logic [2:0] SEL_OPC1   = 3'b100;
  localparam logic [3:0] SEL_CRN    = 4'b0001;
  localparam logic [3:0] SEL_CRM    = 4'b0000;
  localparam logic [2:0] SEL_OPC2   = 3'b011;

  localparam logic [SYN_W-1:0] TRAP_SYNDROME = 6'h03;
endpackage

// File: rtl/cpreg_decode.sv
module cpreg_decode
  import cpreg_pkg::*;
(
  input  logic [3:0] coproc,
  input  logic [2:0] opc1,
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  input  logic [2:0] opc2,
  output logic       hit
);
  logic [4:0] field_eq;

  always_comb begin
    field_eq[0] = (coproc == SEL_COPROC);
    field_eq[1] = (opc1   == SEL_OPC1);
    field_eq[2] = (crn    == SEL_CRN);
    field_eq[3] = (crm    == SEL_CRM);
    field_eq[4] = (opc2   == SEL_OPC2);
    hit         = &field_eq;
  end
endmodule

// File: rtl/cpreg_policy.sv
module cpreg_policy
  import cpreg_pkg::*;
(
  input  logic [1:0] el,
  input  logic       hyp_en,
  input  logic       hyp_is64,
  input  logic       trap64_en,
  input  logic       trap32_en,
  input  logic       nonsecure,
  input  logic       present,
  output outcome_e   verdict
);
  always_comb begin
    verdict = OC_UNDEF;
    if (present) begin
      unique case (el)
        2'd0: verdict = OC_UNDEF;
        2'd1: begin
          if (hyp_en && hyp_is64 && trap64_en)       verdict = OC_TRAP64;
          else if (hyp_en && !hyp_is64 && trap32_en) verdict = OC_TRAP32;
          else                                       verdict = OC_UNDEF;
        end
        2'd2: verdict = OC_OK;
        2'd3: verdict = nonsecure ? OC_OK : OC_UNDEF;
        default: verdict = OC_UNDEF;
      endcase
    end
  end
endmodule

// File: rtl/cpreg_store.sv
module cpreg_store #(
  parameter int HALF_W = 32,
  localparam int FULL_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              narrow_we,
  input  logic [HALF_W-1:0] narrow_wdata,
  input  logic              full_we,
  input  logic [FULL_W-1:0] full_wdata,
  output logic [FULL_W-1:0] full_q
);
  logic [HALF_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic              lo_en, hi_en;

  always_comb begin
    lo_en = full_we;
    lo_d  = full_wdata[HALF_W-1:0];
    hi_en = narrow_we | full_we;
    hi_d  = narrow_we ? narrow_wdata : full_wdata[FULL_W-1:HALF_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (lo_en) lo_q <= lo_d;
      if (hi_en) hi_q <= hi_d;
    end
  end

  assign full_q = {hi_q, lo_q};
endmodule

// File: rtl/cpreg_access_ctl.sv
module cpreg_access_ctl
  import cpreg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [3:0]          req_coproc,
  input  logic [2:0]          req_opc1,
  input  logic [3:0]          req_crn,
  input  logic [3:0]          req_crm,
  input  logic [2:0]          req_opc2,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [1:0]          cur_el,
  input  logic                hyp_en,
  input  logic                hyp_is64,
  input  logic                trap64_en,
  input  logic                trap32_en,
  input  logic                nonsecure,
  input  logic                present,
  input  logic                wide_we,
  input  logic [2*DATA_W-1:0] wide_wdata,
  output logic [2*DATA_W-1:0] wide_rdata,
  output logic                rsp_valid,
  output logic                rsp_nomatch,
  output logic [1:0]          rsp_code,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic [SYN_W-1:0]    rsp_syndrome
);
  localparam int WIDE_W = 2 * DATA_W;

  logic     hit;
  outcome_e verdict;
  logic     sel, ok_acc, ok_wr;

  cpreg_decode i_decode (
    .coproc(req_coproc), .opc1(req_opc1), .crn(req_crn),
    .crm(req_crm), .opc2(req_opc2), .hit(hit)
  );

  cpreg_policy i_policy (
    .el(cur_el), .hyp_en(hyp_en), .hyp_is64(hyp_is64),
    .trap64_en(trap64_en), .trap32_en(trap32_en),
    .nonsecure(nonsecure), .present(present), .verdict(verdict)
  );

  logic [WIDE_W-1:0] store_q;

  cpreg_store #(.HALF_W(DATA_W)) i_store (
    .clk(clk), .rst_n(rst_n),
    .narrow_we(ok_wr), .narrow_wdata(req_wdata),
    .full_we(wide_we), .full_wdata(wide_wdata),
    .full_q(store_q)
  );

  assign wide_rdata = store_q;

  logic              valid_d, valid_q, nomatch_d, nomatch_q;
  logic [1:0]        code_d, code_q;
  logic [DATA_W-1:0] rdata_d, rdata_q;
  logic [SYN_W-1:0]  syn_d, syn_q;

  always_comb begin
    sel       = req_valid & hit;
    ok_acc    = sel & (verdict == OC_OK);
    ok_wr     = ok_acc & req_write;
    valid_d   = req_valid;
    nomatch_d = req_valid & ~hit;
    code_d    = sel ? verdict : OC_OK;
    rdata_d   = (ok_acc && !req_write) ? store_q[WIDE_W-1:DATA_W] : '0;
    syn_d     = (sel && verdict[1]) ? TRAP_SYNDROME : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      nomatch_q <= 1'b0;
      code_q    <= OC_OK;
      rdata_q   <= '0;
      syn_q     <= '0;
    end else begin
      valid_q   <= valid_d;
      nomatch_q <= nomatch_d;
      code_q    <= code_d;
      rdata_q   <= rdata_d;
      syn_q     <= syn_d;
    end
  end

  assign rsp_valid    = valid_q;
  assign rsp_nomatch  = nomatch_q;
  assign rsp_code     = code_q;
  assign rsp_rdata    = rdata_q;
  assign rsp_syndrome = syn_q;
endmodule

// File: rtl/cpreg_access_chk.sv
module cpreg_access_chk
  import cpreg_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic [1:0]          cur_el,
  input logic                nonsecure,
  input logic                present,
  input logic                wide_we,
  input logic [2*DATA_W-1:0] wide_rdata,
  input logic                rsp_valid,
  input logic                rsp_nomatch,
  input logic [1:0]          rsp_code,
  input logic [DATA_W-1:0]   rsp_rdata,
  input logic [SYN_W-1:0]    rsp_syndrome
);
  a_r10_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code != OC_OK) |-> rsp_rdata == '0);

  a_r4_trap_syndrome: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code[1]) |-> rsp_syndrome == TRAP_SYNDROME);

  a_r10_syndrome_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_code[1]) |-> rsp_syndrome == '0);

  a_r3_low_level_undef: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_nomatch && $past(cur_el) == 2'd0) |-> rsp_code == OC_UNDEF);

  a_r2_absent_undef: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_nomatch && !$past(present)) |-> rsp_code == OC_UNDEF);

  a_r8_secure_undef: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_nomatch && $past(cur_el) == 2'd3 && $past(present) && !$past(nonsecure))
      |-> rsp_code == OC_UNDEF);

  a_r1_nomatch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_nomatch && !$past(wide_we)) |-> $stable(wide_rdata));

  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !req_valid) |=> !rsp_valid);
endmodule

bind cpreg_access_ctl cpreg_access_chk i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cur_el(cur_el),
  .nonsecure(nonsecure), .present(present), .wide_we(wide_we),
  .wide_rdata(wide_rdata), .rsp_valid(rsp_valid), .rsp_nomatch(rsp_nomatch),
  .rsp_code(rsp_code), .rsp_rdata(rsp_rdata), .rsp_syndrome(rsp_syndrome)
);

// File: tb/test_cpreg_access_ctl.sv
module test_cpreg_access_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [3:0]  req_coproc, req_crn, req_crm;
  logic [2:0]  req_opc1, req_opc2;
  logic [31:0] req_wdata;
  logic [1:0]  cur_el;
  logic        hyp_en, hyp_is64, trap64_en, trap32_en, nonsecure, present;
  logic        wide_we;
  logic [63:0] wide_wdata, wide_rdata;
  logic        rsp_valid, rsp_nomatch;
  logic [1:0]  rsp_code;
  logic [31:0] rsp_rdata;
  logic [5:0]  rsp_syndrome;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic [63:0] model;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpreg_access_ctl i_cpreg_access_ctl (.*);

  typedef struct packed {
    logic [1:0]  el;
    logic        hen, h64, t64, t32, ns, pres, wr;
    logic [31:0] wd;
    logic [1:0]  exp;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'hA5A5_0001, 2'b00},
    '{2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0,         2'b00},
    '{2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 32'hDEAD_BEEF, 2'b01},
    '{2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0,         2'b01},
    '{2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 32'h1111_2222, 2'b10},
    '{2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0,         2'b11},
    '{2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0,         2'b01},
    '{2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 32'h3333_4444, 2'b01},
    '{2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0,         2'b01},
    '{2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h5555_6666, 2'b01},
    '{2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 32'h1234_5678, 2'b00},
    '{2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0,         2'b00},
    '{2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 32'h7777_8888, 2'b01},
    '{2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0,         2'b01},
    '{2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0,         2'b00},
    '{2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF, 2'b00},
    '{2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 32'h9999_0000, 2'b11},
    '{2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0,         2'b00}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input vec_t v);
    if (!v.pres)          return "R2";
    if (v.el == 2'd0)     return "R3";
    if (v.el == 2'd1) begin
      if (v.exp == 2'b10) return "R4";
      if (v.exp == 2'b11) return "R5";
      return "R6";
    end
    if (v.el == 2'd2)     return "R7";
    return "R8";
  endfunction

  task automatic set_enc(input logic [3:0] cp, input logic [2:0] o1,
                         input logic [3:0] n, input logic [3:0] m, input logic [2:0] o2);
    req_coproc = cp; req_opc1 = o1; req_crn = n; req_crm = m; req_opc2 = o2;
  endtask

  task automatic idle();
    req_valid = 1'b0; req_write = 1'b0; req_wdata = '0; wide_we = 1'b0; wide_wdata = '0;
    set_enc(4'b1111, 3'b100, 4'b0001, 4'b0000, 3'b011);
    cur_el = 2'd2; hyp_en = 1'b1; hyp_is64 = 1'b0; trap64_en = 1'b0; trap32_en = 1'b0;
    nonsecure = 1'b0; present = 1'b1;
  endtask

  // one request at a falling edge, response sampled at the next falling edge
  task automatic issue(input logic wr, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; wide_we = 1'b0;
  endtask

  initial begin
    idle();
    rst_n = 1'b0;
    model = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset rsp_valid", {63'd0, rsp_valid}, 64'd0);
    chk("R11 reset storage", wide_rdata, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      cur_el = VEC[i].el; hyp_en = VEC[i].hen; hyp_is64 = VEC[i].h64;
      trap64_en = VEC[i].t64; trap32_en = VEC[i].t32;
      nonsecure = VEC[i].ns; present = VEC[i].pres;
      issue(VEC[i].wr, VEC[i].wd);
      chk({tag_of(VEC[i]), " outcome"}, {62'd0, rsp_code}, {62'd0, VEC[i].exp});
      chk("R11 response strobe", {63'd0, rsp_valid}, 64'd1);
      chk("R1 matched no nomatch", {63'd0, rsp_nomatch}, 64'd0);
      chk("R10 syndrome", {58'd0, rsp_syndrome}, VEC[i].exp[1] ? 64'h3 : 64'h0);
      chk("R10 read data",  {32'd0, rsp_rdata},
          (VEC[i].exp == 2'b00 && !VEC[i].wr) ? {32'd0, model[63:32]} : 64'd0);
      if (VEC[i].exp == 2'b00 && VEC[i].wr) model[63:32] = VEC[i].wd;
      chk("R10 storage after access", wide_rdata, model);
    end

    // R11 strobe drops after one cycle with no new request
    @(negedge clk);
    chk("R11 single cycle strobe", {63'd0, rsp_valid}, 64'd0);

    // R1 each field off by one bit, EL2 write that would otherwise succeed
    idle();
    for (int f = 0; f < 5; f++) begin
      idle();
      case (f)
        0: req_coproc = 4'b1110;
        1: req_opc1   = 3'b101;
        2: req_crn    = 4'b0011;
        3: req_crm    = 4'b1000;
        default: req_opc2 = 3'b010;
      endcase
      issue(1'b1, 32'hBAD0_0000 | f);
      chk("R1 nomatch flag", {63'd0, rsp_nomatch}, 64'd1);
      chk("R1 nomatch code", {62'd0, rsp_code}, 64'd0);
      chk("R1 nomatch rdata", {32'd0, rsp_rdata}, 64'd0);
      chk("R1 nomatch no write", wide_rdata, model);
    end
    idle();

    // R9 64-bit write seen by a 32-bit read
    @(negedge clk);
    wide_we = 1'b1; wide_wdata = 64'h0123_4567_89AB_CDEF;
    @(negedge clk);
    wide_we = 1'b0;
    model = 64'h0123_4567_89AB_CDEF;
    chk("R9 wide write visible", wide_rdata, model);
    issue(1'b0, 32'h0);
    chk("R9 narrow read of wide write", {32'd0, rsp_rdata}, 64'h0123_4567);
    issue(1'b1, 32'hCAFE_F00D);
    model[63:32] = 32'hCAFE_F00D;
    chk("R9 narrow write upper only", wide_rdata, model);

    // R12 simultaneous writes
    @(negedge clk);
    wide_we = 1'b1; wide_wdata = 64'h1111_1111_2222_2222;
    req_valid = 1'b1; req_write = 1'b1; req_wdata = 32'h4444_5555;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; wide_we = 1'b0;
    chk("R12 merged halves", wide_rdata, 64'h4444_5555_2222_2222);

    // R12 wide write with a refused narrow write: wide data fully taken
    @(negedge clk);
    cur_el = 2'd0;
    wide_we = 1'b1; wide_wdata = 64'hAAAA_BBBB_CCCC_DDDD;
    req_valid = 1'b1; req_write = 1'b1; req_wdata = 32'h0;
    @(negedge clk);
    req_valid = 1'b0; wide_we = 1'b0;
    chk("R12 refused narrow keeps wide", wide_rdata, 64'hAAAA_BBBB_CCCC_DDDD);
    chk("R3 refused outcome", {62'd0, rsp_code}, 64'd1);

    // R11 reset clears storage
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 reset clears storage", wide_rdata, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule